// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a bank of general-purpose I/O lines behind a single-cycle register port. Software drives line levels in one of three ways. It can load the whole output latch at once. It can raise selected lines through a set register. It can lower selected lines through a clear register. Set and clear need no read-modify-write. Line direction can be programmed through either of two registers, one active-high for output and one active-high for input. Both views are backed by a single direction state, so each always reads as the bitwise complement of the other.

The register width is a parameter of 1, 2, 4 or 8 bytes, and there is one GPIO line per register bit. Two elaboration options change how lines map onto bus bits:
- a mirrored order, which places line n at bit (width-1-n);
- a byte swap, which reverses the byte order of 16- and 32-bit accesses.

Asking for a byte swap at 64-bit width stops elaboration with an error. Pad inputs pass through a two-flop synchroniser before they can be read.

Top module: `gpio_regs`

## Requirements
- R1: While reset is asserted and after it is released, the output latch and all output enables are zero, the output-direction register reads zero and the input-direction register reads all ones.
- R2: Register selects on addr_i are: 0 data, 1 set, 2 clear, 3 output-direction, 4 input-direction. A write to the data register loads the output latch for every line. A write to any other select value is ignored, and reading it returns zero.
- R3: A write to the set register forces high every line whose bus bit is 1 and leaves the other lines unchanged. Reading the set register returns the output latch.
- R4: A write to the clear register forces low every line whose bus bit is 1 and leaves the other lines unchanged. Reading the clear register returns zero.
- R5: Writing the output-direction register makes lines with a 1 bit outputs (pad_oe_o high) and lines with a 0 bit inputs. Afterwards the input-direction register reads back as its complement.
- R6: Writing the input-direction register makes lines with a 1 bit inputs and lines with a 0 bit outputs. Afterwards the output-direction register reads back as its complement.
- R7: For output lines, a data register read returns the output latch. For input lines, it returns the pad level after two synchronising flops. A pad change that is presented before edge 1 appears in read data captured at edge 3 and not earlier.
- R8: With the mirrored-order option, line n is held at bus bit (width-1-n) in every register. Without it, line n is held at bus bit n.
- R9: With the byte-swap option at 16- or 32-bit width, bus byte b carries register byte (bytes-1-b) in both directions, with bit order inside each byte kept.
- R10: Read data is registered. rdata_o after an edge holds the register selected by addr_i at that edge, as it stood before any write on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select |
| we_i | input | 1 | Write enable for the selected register |
| wdata_i | input | NBYTES*8 | Write data |
| rdata_o | output | NBYTES*8 | Registered read data |
| pad_i | input | NBYTES*8 | Pad input levels, asynchronous |
| pad_o | output | NBYTES*8 | Output latch driven to the pads |
| pad_oe_o | output | NBYTES*8 | Per-line output enable |

## Verification
Results arrive on three different schedules:
- Latch and direction writes reach pad_o and pad_oe_o on the edge that samples the write, so the bench checks the pads at the following falling edge.
- A read returns its register one edge after the select is presented. A monitor records the request at that edge and compares 1 ns later against an expectation queued by the driver.
- A pad input change takes three edges to reach rdata_o. Back-to-back reads issued with the change expect the old, old, then new level.

Three instances share the bus: plain order, mirrored and byte-swapped. The same register traffic is therefore checked against three different pad mappings.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_DOUT = 3'd3,
    SEL_DIN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_lane_map.sv
// Bus <-> line permutation. Byte swap and mirror commute and each is its own
// inverse, so one instance serves both the write and the read direction.
module gpio_lane_map #(
  parameter int unsigned NBYTES    = 4,
  parameter bit          MIRROR    = 1'b0,
  parameter bit          BYTE_SWAP = 1'b0
) (
  input  logic [NBYTES*8-1:0] in_i,
  output logic [NBYTES*8-1:0] out_o
);
  localparam int unsigned W       = NBYTES * 8;
  localparam bit          DO_SWAP = BYTE_SWAP && (NBYTES == 2 || NBYTES == 4);

  logic [W-1:0] swapped;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (DO_SWAP) begin : g_swap
      assign swapped[8*b +: 8] = in_i[8*(NBYTES-1-b) +: 8];
    end else begin : g_keep
      assign swapped[8*b +: 8] = in_i[8*b +: 8];
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (MIRROR) begin : g_mir
      assign out_o[k] = swapped[W-1-k];
    end else begin : g_str
      assign out_o[k] = swapped[k];
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NBYTES    = 4,
  parameter bit          MIRROR    = 1'b0,
  parameter bit          BYTE_SWAP = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NBYTES*8-1:0] wdata_i,
  output logic [NBYTES*8-1:0] rdata_o,
  input  logic [NBYTES*8-1:0] pad_i,
  output logic [NBYTES*8-1:0] pad_o,
  output logic [NBYTES*8-1:0] pad_oe_o
);
  localparam int unsigned W = NBYTES * 8;

  if (!(NBYTES == 1 || NBYTES == 2 || NBYTES == 4 || NBYTES == 8)) begin : g_bad_width
    $error("gpio_regs: NBYTES must be 1, 2, 4 or 8");
  end
  if (BYTE_SWAP && NBYTES == 8) begin : g_bad_swap
    $error("gpio_regs: byte swap is not allowed at 64-bit width");
  end

  logic [W-1:0] wline;    // write data in line order
  logic [W-1:0] latch_q;  // output latch, line order
  logic [W-1:0] dir_q;    // 1 = output, line order
  logic [W-1:0] pad_sync;
  logic [W-1:0] rline, rbus, rdata_q;

  gpio_lane_map #(.NBYTES(NBYTES), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
    .in_i (wdata_i),
    .out_o(wline)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        SEL_DATA: latch_q <= wline;
        SEL_SET:  latch_q <= latch_q | wline;
        SEL_CLR:  latch_q <= latch_q & ~wline;
        SEL_DOUT: dir_q   <= wline;
        SEL_DIN:  dir_q   <= ~wline;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      SEL_DATA: rline = (latch_q & dir_q) | (pad_sync & ~dir_q);
      SEL_SET:  rline = latch_q;
      SEL_DOUT: rline = dir_q;
      SEL_DIN:  rline = ~dir_q;
      default:  rline = '0;
    endcase
  end

  gpio_lane_map #(.NBYTES(NBYTES), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
    .in_i (rline),
    .out_o(rbus)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rbus;
  end

  assign rdata_o  = rdata_q;
  assign pad_o    = latch_q;
  assign pad_oe_o = dir_q;
endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   addr_i,
  input logic         we_i,
  input logic [W-1:0] wline_i,
  input logic [W-1:0] latch_i,
  input logic [W-1:0] dir_i,
  input logic [W-1:0] rdata_i,
  input logic [W-1:0] pad_o_i,
  input logic [W-1:0] pad_oe_i
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (pad_o_i == '0 && pad_oe_i == '0); // R1
    end
  end

  AST_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd1) |=>
      ((latch_i & $past(wline_i)) == $past(wline_i)) &&
      ((latch_i & ~$past(wline_i)) == ($past(latch_i) & ~$past(wline_i)))); // R3

  AST_CLR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd2) |=>
      ((latch_i & $past(wline_i)) == '0) &&
      ((latch_i & ~$past(wline_i)) == ($past(latch_i) & ~$past(wline_i)))); // R4

  AST_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd2) |=> (rdata_i == '0)); // R4

  AST_DIR_OUT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd3) |=> (dir_i == $past(wline_i))); // R5

  AST_DIR_IN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd4) |=> (dir_i == ~$past(wline_i))); // R6
endmodule

bind gpio_regs gpio_regs_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wline_i (wline),
  .latch_i (latch_q),
  .dir_i   (dir_q),
  .rdata_i (rdata_o),
  .pad_o_i (pad_o),
  .pad_oe_i(pad_oe_o)
);

// File: tb/tb_gpio_regs.sv
`timescale 1ns/1ps
module tb_gpio_regs;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] rdata [3];
  logic [W-1:0] po [3];
  logic [W-1:0] poe [3];
  logic         rd_req = 1'b0;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_regs #(.NBYTES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata[0]), .pad_i(pad_in), .pad_o(po[0]), .pad_oe_o(poe[0]));
  gpio_regs #(.NBYTES(4), .MIRROR(1'b1)) dut_mir (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata[1]), .pad_i(pad_in), .pad_o(po[1]), .pad_oe_o(poe[1]));
  gpio_regs #(.NBYTES(4), .BYTE_SWAP(1'b1)) dut_swp (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata[2]), .pad_i(pad_in), .pad_o(po[2]), .pad_oe_o(poe[2]));

  // Bus-order model
  logic [W-1:0] lat_b = '0;
  logic [W-1:0] dir_b = '0;
  logic [W-1:0] pad_m = '0;

  // Line vector -> bus bits for instance k (0 plain, 1 mirrored R8, 2 byte-swapped R9)
  function automatic logic [W-1:0] perm(int k, logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (k == 1)      r[i] = x[W-1-i];
      else if (k == 2) r[i] = x[8*(3 - i/8) + (i%8)];
      else             r[i] = x[i];
    end
    return r;
  endfunction

  function automatic string inst_req(int k);
    if (k == 1) return "R8";
    if (k == 2) return "R9";
    return "R2";
  endfunction

  function automatic logic [W-1:0] exp_read(int k, logic [2:0] a);
    case (a)
      3'd0: return (lat_b & dir_b) | (perm(k, pad_m) & ~dir_b);
      3'd1: return lat_b;
      3'd3: return dir_b;
      3'd4: return ~dir_b;
      default: return '0;
    endcase
  endfunction

  // Scoreboard queues
  logic [W-1:0] q_exp [3][$];
  string        q_tag [$];

  task automatic check(string tag, int k, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s inst%0d(%s): actual=%h expected=%h", tag, k, inst_req(k), act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    rd_req = 1'b0; addr = a; we = 1'b1; wdata = d;
    case (a)
      3'd0: lat_b = d;
      3'd1: lat_b = lat_b | d;
      3'd2: lat_b = lat_b & ~d;
      3'd3: dir_b = d;
      3'd4: dir_b = ~d;
      default: ;
    endcase
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_exp(logic [2:0] a, logic [W-1:0] e0, logic [W-1:0] e1,
                        logic [W-1:0] e2, string tag);
    @(negedge clk);
    we = 1'b0; addr = a; rd_req = 1'b1;
    q_exp[0].push_back(e0); q_exp[1].push_back(e1); q_exp[2].push_back(e2);
    q_tag.push_back(tag);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    rd_exp(a, exp_read(0, a), exp_read(1, a), exp_read(2, a), tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    rd_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_pads(string tag);
    for (int k = 0; k < 3; k++) begin
      check(tag, k, po[k], perm(k, lat_b));
      check(tag, k, poe[k], perm(k, dir_b));
    end
  endtask

  // Monitor: read issued before an edge is compared 1 ns after it (R10)
  initial begin
    forever begin
      logic hit;
      @(posedge clk);
      hit = rd_req;
      #1;
      if (hit) begin
        string t;
        t = q_tag.pop_front();
        for (int k = 0; k < 3; k++) check(t, k, rdata[k], q_exp[k].pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] newpad;
    repeat (3) @(negedge clk);
    chk_pads("R1 in reset");
    rst_n = 1'b1;
    rd(3'd3, "R1 dout after reset");
    rd(3'd4, "R1 din after reset");

    wr(3'd0, 32'hA5C3_0F81);
    chk_pads("R2 data write");
    rd(3'd1, "R3 set readback of latch");

    wr(3'd1, 32'h0000_F00F);
    chk_pads("R3 set ones");
    rd(3'd1, "R3 set readback");

    wr(3'd2, 32'h8100_0003);
    chk_pads("R4 clear ones");
    rd(3'd2, "R4 clear reads zero");

    wr(3'd3, 32'h0000_FFFF);
    chk_pads("R5 dout write");
    rd(3'd4, "R5 din complement");
    rd(3'd3, "R5 dout readback");

    wr(3'd4, 32'h0F0F_0F0F);
    chk_pads("R6 din write");
    rd(3'd3, "R6 dout complement");

    // R7 synchroniser latency: old, old, new
    newpad = 32'h3C3C_5AA5;
    @(negedge clk);
    rd_req = 1'b0;
    rd_exp(3'd0, exp_read(0, 3'd0), exp_read(1, 3'd0), exp_read(2, 3'd0), "R7 before sync edge1");
    pad_in = newpad;
    rd(3'd0, "R7 before sync edge2");
    pad_m = newpad;
    rd(3'd0, "R7 synced edge3");
    rd(3'd0, "R7 synced steady");

    wr(3'd3, 32'hFFFF_0000);
    rd(3'd0, "R7 mixed directions");
    pad_in = 32'h0123_4567; pad_m = pad_in;
    idle(3);
    rd(3'd0, "R7 new pad pattern");

    // R2 unused select ignored
    wr(3'd6, 32'hFFFF_FFFF);
    chk_pads("R2 unused write ignored");
    rd(3'd6, "R2 unused reads zero");
    rd(3'd1, "R2 latch kept after unused write");
    rd(3'd3, "R2 dir kept after unused write");

    // R8/R9 single-line mapping
    wr(3'd0, 32'h0000_0001);
    chk_pads("R8 single bit map");
    wr(3'd0, 32'h8000_0100);
    chk_pads("R9 single bit map");
    rd(3'd1, "R9 readback round trip");

    idle(4);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule